// File: doc/BRIEF.md
# PCM sample to single-precision float converter

This block turns one 16-bit PCM audio code into an IEEE-754 single-precision value in a single registered stage. A mode input selects how the code is read. In signed mode the code is two's complement and is scaled by 1/32768, so the full range maps onto [-1.0, 1.0). In unsigned mode the code is a plain magnitude and is scaled by 1/65536, so the full range maps onto [0.0, 1.0).

The datapath has four steps:
- It forms a magnitude and a sign from the code.
- A leading-one detector finds the top set bit of that magnitude.
- The exponent field is built from the position of that bit.
- The magnitude is left-aligned to form the fraction field.

Zero and the most negative signed code are handled as explicit special cases. Every 16-bit code fits inside the 24-bit significand, so the result is always exact and no rounding is needed. A valid strobe travels alongside the data with one cycle of latency.

Top module: `pcm_to_float`

## Requirements
- R1: An input code of 0x0000 produces the output word 0x00000000 in both modes.
- R2: In signed mode (signed_mode_i = 1), the code 0x8000 produces exactly 0xBF800000 (-1.0).
- R3: In signed mode, a nonzero code with bit 15 set is converted from the 16-bit two's-complement magnitude of the code, with any carry above bit 15 dropped, and output bit 31 is set. Output bit 31 is clear when input bit 15 is clear.
- R4: For a nonzero magnitude whose highest set bit is at position p, the output exponent field (bits 30..23) equals 112 + p in signed mode and 111 + p in unsigned mode.
- R5: The output fraction field (bits 22..0) equals the magnitude shifted left by 23 - p, with the leading one at bit 23 removed. All fraction bits below the shifted magnitude are zero.
- R6: In unsigned mode (signed_mode_i = 0), all 16 input bits are read as a magnitude and output bit 31 is always 0.
- R7: The conversion is exact. Decoding the output back into a 16-bit code (multiplying by 32768 in signed mode, or by 65536 in unsigned mode) returns the input code for every code in both modes. In signed mode, 0x8000 returns 0x8000.
- R8: out_valid_o equals in_valid_i delayed by one clock. out_data_o loads only on a clock edge where in_valid_i is high, and it holds its value otherwise.
- R9: While rst_ni is low, out_valid_o and out_data_o are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input code is valid this cycle |
| in_data_i | input | 16 | PCM code |
| signed_mode_i | input | 1 | 1: two's complement scaled by 1/32768; 0: unsigned scaled by 1/65536 |
| out_valid_o | output | 1 | out_data_o was loaded on the last edge |
| out_data_o | output | 32 | IEEE-754 single-precision result |

## Verification
The bench builds the block with its default parameters: a 16-bit code, an 8-bit exponent with bias 127, and a 23-bit fraction. At these values the entire input space is only 2 × 65536 codes. That is small enough to stream every code in both modes back to back and compare each result against an expected word taken from the host's double-precision encoding of code/32768 or code/65536. Every result is also decoded back into a code, which checks exactness directly. A short vector table and directed steps cover the special codes, the hold behaviour when the strobe is low, and reset in the middle of a run.

// File: rtl/pcm_to_float_pkg.sv
package pcm_to_float_pkg;
  localparam int unsigned CODE_W = 16;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned BIAS   = 127;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned POS_W  = $clog2(CODE_W);

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } sp_float_t;
endpackage

// File: rtl/pcm_to_float_mag.sv
// Sign/magnitude front end: masks in unsigned mode, negates in signed mode.
module pcm_to_float_mag #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] code_i,
  input  logic         signed_mode_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o,
  output logic         is_zero_o,
  output logic         is_min_o
);
  logic [W-1:0] min_code;
  assign min_code = {1'b1, {(W-1){1'b0}}};

  assign neg_o     = signed_mode_i & code_i[W-1];
  // carry above the top bit falls off the W-bit sum
  assign mag_o     = neg_o ? (~code_i + W'(1)) : code_i;
  assign is_zero_o = (code_i == '0);
  assign is_min_o  = signed_mode_i & (code_i == min_code);
endmodule

// File: rtl/pcm_to_float_lod.sv
// Leading-one detector: position of highest set bit.
module pcm_to_float_lod #(
  parameter int unsigned W = 16,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o
);
  logic [W-1:0] above;
  logic [W-1:0] top_hot;

  assign above[W-1] = 1'b0;
  generate
    for (genvar i = 0; i < W - 1; i++) begin : g_above
      assign above[i] = above[i+1] | vec_i[i+1];
    end
    for (genvar i = 0; i < W; i++) begin : g_hot
      assign top_hot[i] = vec_i[i] & ~above[i];
    end
  endgenerate

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (top_hot[i]) pos_o = pos_o | PW'(i);
    end
  end
endmodule

// File: rtl/pcm_to_float_pack.sv
// Builds exponent and fraction fields; applies special cases.
module pcm_to_float_pack
  import pcm_to_float_pkg::*;
(
  input  logic [CODE_W-1:0] mag_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              neg_i,
  input  logic              is_zero_i,
  input  logic              is_min_i,
  input  logic              signed_mode_i,
  output sp_float_t         res_o
);
  localparam int unsigned SH_W  = $clog2(FRAC_W + 1);
  localparam int unsigned BODY_W = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expo;
  logic [SH_W-1:0]   sh_amt;
  logic [FRAC_W:0]   aligned;
  logic [BODY_W-1:0] body;
  sp_float_t         norm;

  // signed scale is one binade higher than unsigned
  assign expo    = EXP_W'(BIAS - CODE_W) + EXP_W'(pos_i) + EXP_W'(signed_mode_i);
  assign sh_amt  = SH_W'(FRAC_W) - SH_W'(pos_i);
  assign aligned = (FRAC_W + 1)'(mag_i) << sh_amt;
  // drop hidden one at FRAC_W, then insert exponent
  assign body    = (BODY_W'(aligned) & ~(BODY_W'(1) << FRAC_W))
                 | {expo, {FRAC_W{1'b0}}};

  assign norm = sp_float_t'({neg_i, body});

  always_comb begin
    if (is_zero_i)
      res_o = '0;
    else if (is_min_i)
      res_o = '{sign: 1'b1, expo: EXP_W'(BIAS), frac: '0};
    else
      res_o = norm;
  end
endmodule

// File: rtl/pcm_to_float.sv
module pcm_to_float
  import pcm_to_float_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [CODE_W-1:0] in_data_i,
  input  logic              signed_mode_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o
);
  logic [CODE_W-1:0] mag;
  logic [POS_W-1:0]  pos;
  logic              neg, is_zero, is_min;
  sp_float_t         res;
  sp_float_t         res_q;
  logic              vld_q;

  pcm_to_float_mag #(.W(CODE_W)) u_mag (
    .code_i        (in_data_i),
    .signed_mode_i (signed_mode_i),
    .mag_o         (mag),
    .neg_o         (neg),
    .is_zero_o     (is_zero),
    .is_min_o      (is_min)
  );

  pcm_to_float_lod #(.W(CODE_W)) u_lod (
    .vec_i (mag),
    .pos_o (pos)
  );

  pcm_to_float_pack u_pack (
    .mag_i         (mag),
    .pos_i         (pos),
    .neg_i         (neg),
    .is_zero_i     (is_zero),
    .is_min_i      (is_min),
    .signed_mode_i (signed_mode_i),
    .res_o         (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) res_q <= res;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = res_q;
endmodule

// File: rtl/pcm_to_float_chk.sv
module pcm_to_float_chk
  import pcm_to_float_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [CODE_W-1:0] in_data_i,
  input logic              signed_mode_i,
  input logic              out_valid_o,
  input logic [WORD_W-1:0] out_data_o
);
  localparam logic [CODE_W-1:0] MIN_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [EXP_W-1:0]  EXP_LO   = EXP_W'(BIAS - CODE_W);
  localparam logic [EXP_W-1:0]  EXP_HI   = EXP_W'(BIAS);

  p_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_data_i == '0) |=> (out_data_o == '0));

  p_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && signed_mode_i && in_data_i == MIN_CODE) |=> (out_data_o == 32'hBF80_0000));

  p_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && signed_mode_i && in_data_i != '0) |=> (out_data_o[WORD_W-1] == $past(in_data_i[CODE_W-1])));

  p_exp_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_data_o != '0) |->
      (out_data_o[WORD_W-2 -: EXP_W] >= EXP_LO && out_data_o[WORD_W-2 -: EXP_W] <= EXP_HI));

  p_unsigned_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !signed_mode_i) |=> !out_data_o[WORD_W-1]);

  p_vld_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_vld_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r9: assert (!out_valid_o && out_data_o == '0);
    end
  end
endmodule

bind pcm_to_float pcm_to_float_chk u_chk (.*);

// File: tb/pcm_to_float_test.sv
module pcm_to_float_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        signed_mode_i = 1'b0;
  logic        out_valid_o;
  logic [31:0] out_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  pcm_to_float uut (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: actual cycles=%0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // expected word from host double encoding of the scaled value
  function automatic logic [31:0] ref_word(input logic sm, input logic [15:0] code);
    real r;
    logic [63:0] b;
    int e;
    if (sm) r = $itor($signed(code)) / 32768.0;
    else    r = $itor({16'd0, code}) / 65536.0;
    if (r == 0.0) return 32'h0;
    b = $realtobits(r);
    e = int'(b[62:52]) - 1023 + 127;
    return {b[63], e[7:0], b[51:29]};
  endfunction

  // decode a result back into a code
  function automatic logic [15:0] back_code(input logic sm, input logic [31:0] w);
    logic [31:0] m;
    int sh;
    if (w == 32'h0) return 16'h0;
    m  = {8'd0, 1'b1, w[22:0]};
    sh = (sm ? 135 : 134) - int'(w[30:23]);
    m  = m >> sh;
    if (w[31]) m = -m;
    return m[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // {signed_mode, code, expected word}
  localparam int NV = 13;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 16'h0000, 32'h0000_0000},   // R1
    {1'b0, 16'h0000, 32'h0000_0000},   // R1
    {1'b1, 16'h8000, 32'hBF80_0000},   // R2
    {1'b1, 16'hFFFF, 32'hB800_0000},   // R3
    {1'b1, 16'hC000, 32'hBF00_0000},   // R3
    {1'b1, 16'h0001, 32'h3800_0000},   // R4 p=0
    {1'b1, 16'h4000, 32'h3F00_0000},   // R4 p=14
    {1'b1, 16'h7FFF, 32'h3F7F_FE00},   // R5
    {1'b1, 16'h0003, 32'h38C0_0000},   // R5
    {1'b0, 16'h0001, 32'h3780_0000},   // R4 unsigned p=0
    {1'b0, 16'h8000, 32'h3F00_0000},   // R6
    {1'b0, 16'hFFFF, 32'h3F7F_FF00},   // R6
    {1'b0, 16'hC000, 32'h3F40_0000}    // R6
  };

  logic [31:0] held;
  logic        p_sm;
  logic [15:0] p_code;

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset valid", {31'd0, out_valid_o}, 32'd0);
    check("R9 reset data", out_data_o, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      in_valid_i    = 1'b1;
      signed_mode_i = VEC[i][48];
      in_data_i     = VEC[i][47:32];
      @(negedge clk_i);
      in_valid_i = 1'b0;
      check("R1-R6 vector", out_data_o, VEC[i][31:0]);
      check("R8 valid", {31'd0, out_valid_o}, 32'd1);
    end

    // R8: strobe low, data changes, output must hold
    @(negedge clk_i);
    held = out_data_o;
    in_valid_i = 1'b0; signed_mode_i = 1'b1; in_data_i = 16'h1234;
    @(negedge clk_i);
    check("R8 hold data", out_data_o, held);
    check("R8 no valid", {31'd0, out_valid_o}, 32'd0);

    // exhaustive sweep, both modes, back to back
    for (int i = 0; i < 131072; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        check("R4/R5 sweep", out_data_o, ref_word(p_sm, p_code));
        check("R7 round trip", {16'd0, back_code(p_sm, out_data_o)}, {16'd0, p_code});
      end
      p_sm          = (i >= 65536);
      p_code        = i[15:0];
      in_valid_i    = 1'b1;
      signed_mode_i = p_sm;
      in_data_i     = p_code;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R4/R5 sweep", out_data_o, ref_word(p_sm, p_code));
    check("R7 round trip", {16'd0, back_code(p_sm, out_data_o)}, {16'd0, p_code});

    // R7: signed 0x8000 returns 0x8000
    @(negedge clk_i);
    in_valid_i = 1'b1; signed_mode_i = 1'b1; in_data_i = 16'h8000;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R7 min round trip", {16'd0, back_code(1'b1, out_data_o)}, 32'h0000_8000);

    // R9: reset mid-run with nonzero output
    @(negedge clk_i);
    in_valid_i = 1'b1; signed_mode_i = 1'b0; in_data_i = 16'hFFFF;
    @(negedge clk_i);
    in_valid_i = 1'b1;
    rst_ni = 1'b0;
    #1;
    check("R9 async clear data", out_data_o, 32'd0);
    check("R9 async clear valid", {31'd0, out_valid_o}, 32'd0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    rst_ni = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule